// File: doc/BRIEF.md
# Byte-wide Upward-growing Hardware Stack

This block keeps a last-in first-out stack of bytes in a small on-chip RAM, addressed by an 8-bit stack pointer that grows toward higher addresses. A push first advances the pointer by one and then stores the byte at the new address. A pop first reads the byte at the current address and then moves the pointer back by one. After reset the pointer sits at 07H, so the first byte pushed lands at 08H.

A 16-bit value moves as two byte operations on consecutive cycles. A wide push stores the low byte first and the high byte second. A wide pop returns the high byte first and the low byte second, and then presents the whole word. The block never writes past the top RAM address and never pops below the reset pointer. Either case is refused and raises a sticky status flag. A push and a pop requested in the same cycle are refused and produce a one-cycle error pulse. The pointer can be loaded directly, and a direct load wins over any push or pop in the same cycle.

Top module: `byte_stack_unit`

## Requirements
- R1: The storage holds DEPTH (128) bytes at addresses 00H..7FH, and a byte pushed at an address is returned unchanged by the pop that reads that address.
- R2: While reset is high at a clock edge, the pointer becomes 07H, the overflow, underflow and error outputs become 0, and `rd_valid`, `word_valid` and `busy` become 0.
- R3: An accepted push increments the pointer by 1 and writes the byte at the incremented address. The change is visible after the clock edge that samples the request.
- R4: An accepted pop returns the byte at the current pointer on `rd_byte` with `rd_valid` high in the cycle after the sampling edge, and decrements the pointer by 1 at that same edge.
- R5: A push with `wide`=1 writes `wr_word[7:0]` at the first edge and `wr_word[15:8]` at the next edge. `busy` is high for the one cycle between them, and request inputs are ignored during that cycle.
- R6: A pop with `wide`=1 returns the high byte (at the current pointer) first and the low byte second. In the cycle after the second byte, `word_valid` is 1 and `rd_word` = {high, low}.
- R7: When `push_req` and `pop_req` are both high while the block is idle and no pointer load is requested, neither operation runs, the pointer is unchanged, and `conflict_err` is high for exactly the following cycle.
- R8: A push while the pointer is at or above 7FH does not write and does not move the pointer, and it sets `ovf_flag`, which stays at 1 until reset.
- R9: A pop while the pointer is at or below 07H does not read (`rd_valid` stays 0) and does not move the pointer, and it sets `udf_flag`, which stays at 1 until reset.
- R10: When `sp_wr_en` is high, the pointer takes `sp_wr_val` at that edge, and any push or pop requested in the same cycle is dropped. This includes the pending second byte of a wide operation.
- R11: The byte order is last-in first-out: bytes pushed as A then B pop as B then A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| wide | input | 1 | 1 = the request is a 16-bit two-byte operation |
| wr_word | input | 16 | Data to push; byte operations use bits [7:0] |
| sp_wr_en | input | 1 | Direct pointer load |
| sp_wr_val | input | 8 | Value to load into the pointer |
| sp_out | output | 8 | Current stack pointer |
| rd_byte | output | 8 | Last popped byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_byte` |
| rd_word | output | 16 | Word assembled by a wide pop |
| word_valid | output | 1 | One-cycle strobe for `rd_word` |
| busy | output | 1 | Second byte of a wide operation in progress |
| conflict_err | output | 1 | One-cycle pulse on a simultaneous push and pop |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |

## Verification
The hardest case to reach is a pointer load that lands during the second cycle of a wide push, because it only matters in the single cycle while `busy` is high. The stimulus first loads the pointer to a known address, starts a wide push, and raises `sp_wr_en` on exactly the following negative edge. It then checks the final pointer value and reads back the surviving low byte through a pop. The top-of-RAM refusal is reached the same way: the pointer is loaded next to the top, a byte is placed there, and that byte is shown to survive a refused push.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;

    // role of a byte operation inside a (possibly two-byte) request
    typedef enum logic [1:0] {
        TAG_SINGLE     = 2'd0,
        TAG_WIDE_FIRST = 2'd1,
        TAG_WIDE_LAST  = 2'd2
    } op_tag_e;

    typedef struct packed {
        logic              valid;
        logic              is_push;
        op_tag_e           tag;
        logic [BYTE_W-1:0] data;
    } byte_op_t;

    function automatic byte_op_t idle_op();
        byte_op_t o;
        o.valid   = 1'b0;
        o.is_push = 1'b0;
        o.tag     = TAG_SINGLE;
        o.data    = '0;
        return o;
    endfunction

endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [stk_pkg::BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [stk_pkg::BYTE_W-1:0] rdata
);
    logic [stk_pkg::BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        push_req,
    input  logic        pop_req,
    input  logic        wide,
    input  logic [15:0] wr_word,
    input  logic        sp_wr_en,
    input  logic        refused,
    output byte_op_t    op,
    output logic        busy,
    output logic        conflict_err
);
    typedef enum logic {S_IDLE, S_SECOND} seq_st_e;

    seq_st_e           st_q, st_d;
    logic              kind_q;
    logic [BYTE_W-1:0] hold_q;
    logic              clash;

    always_comb begin
        op    = idle_op();
        st_d  = S_IDLE;
        clash = 1'b0;
        if (st_q == S_IDLE) begin
            if (!sp_wr_en) begin
                if (push_req && pop_req) begin
                    clash = 1'b1;
                end else if (push_req || pop_req) begin
                    op.valid   = 1'b1;
                    op.is_push = push_req;
                    op.tag     = wide ? TAG_WIDE_FIRST : TAG_SINGLE;
                    op.data    = wr_word[BYTE_W-1:0];
                    if (wide && !refused) st_d = S_SECOND;
                end
            end
        end else if (!sp_wr_en) begin
            op.valid   = 1'b1;
            op.is_push = kind_q;
            op.tag     = TAG_WIDE_LAST;
            op.data    = hold_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= S_IDLE;
            kind_q       <= 1'b0;
            hold_q       <= '0;
            conflict_err <= 1'b0;
        end else begin
            st_q         <= st_d;
            conflict_err <= clash;
            if (st_q == S_IDLE) begin
                kind_q <= push_req;
                hold_q <= wr_word[15:8];
            end
        end
    end

    assign busy = (st_q == S_SECOND);

    // R5: the second byte slot lasts exactly one cycle
    a_r5_second_slot_single: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R5: after an accepted wide push, the next byte offered is the high half
    a_r5_high_follows_low: assert property (@(posedge clk) disable iff (rst)
        (!busy && op.valid && op.is_push && op.tag == TAG_WIDE_FIRST && !refused)
        |=> (sp_wr_en || (op.valid && op.data == $past(wr_word[15:8]))));

    // R7: an error pulse only follows a real clash while idle
    a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
        conflict_err |-> $past(push_req && pop_req && !sp_wr_en && !busy));
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter logic [PTR_W-1:0] BASE_SP = 8'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  byte_op_t          op,
    input  logic              sp_wr_en,
    input  logic [PTR_W-1:0]  sp_wr_val,
    output logic [PTR_W-1:0]  sp,
    output logic              refused,
    output logic              do_push,
    output logic              do_pop,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W-1:0] raddr,
    output logic              ovf_flag,
    output logic              udf_flag
);
    localparam logic [PTR_W-1:0] TOP_SP = PTR_W'(DEPTH - 1);

    logic             at_top, at_base;
    logic [PTR_W-1:0] sp_inc, sp_dec;

    assign at_top  = (sp >= TOP_SP);
    assign at_base = (sp <= BASE_SP);
    assign sp_inc  = sp + PTR_W'(1);
    assign sp_dec  = sp - PTR_W'(1);

    assign do_push = op.valid &&  op.is_push && !at_top;
    assign do_pop  = op.valid && !op.is_push && !at_base;
    assign refused = op.valid && (op.is_push ? at_top : at_base);
    assign waddr   = sp_inc[ADDR_W-1:0];
    assign raddr   = sp[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp       <= BASE_SP;
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            if (sp_wr_en)     sp <= sp_wr_val;
            else if (do_push) sp <= sp_inc;
            else if (do_pop)  sp <= sp_dec;
            if (op.valid &&  op.is_push && at_top)  ovf_flag <= 1'b1;
            if (op.valid && !op.is_push && at_base) udf_flag <= 1'b1;
        end
    end

    // R2: pointer leaves reset at the base value
    a_r2_reset_base: assert property (@(posedge clk)
        $past(rst) |-> (sp == BASE_SP && !ovf_flag && !udf_flag));

    // R3: accepted push advances the pointer by one
    a_r3_push_step: assert property (@(posedge clk) disable iff (rst)
        (do_push && !sp_wr_en) |=> sp == $past(sp) + PTR_W'(1));

    // R4: accepted pop retreats the pointer by one
    a_r4_pop_step: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !sp_wr_en) |=> sp == $past(sp) - PTR_W'(1));

    // R8: overflow flag is sticky
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    // R9: underflow flag is sticky
    a_r9_udf_sticky: assert property (@(posedge clk) disable iff (rst)
        udf_flag |=> udf_flag);

    // R10: a direct load always lands
    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        sp_wr_en |=> sp == $past(sp_wr_val));
endmodule

// File: rtl/byte_stack_unit.sv
module byte_stack_unit
    import stk_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter logic [7:0] BASE_SP = 8'h07
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_req,
    input  logic        pop_req,
    input  logic        wide,
    input  logic [15:0] wr_word,
    input  logic        sp_wr_en,
    input  logic [7:0]  sp_wr_val,
    output logic [7:0]  sp_out,
    output logic [7:0]  rd_byte,
    output logic        rd_valid,
    output logic [15:0] rd_word,
    output logic        word_valid,
    output logic        busy,
    output logic        conflict_err,
    output logic        ovf_flag,
    output logic        udf_flag
);
    localparam int ADDR_W = $clog2(DEPTH);

    byte_op_t          op;
    logic              refused, do_push, do_pop;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [BYTE_W-1:0] rdata, hi_q;

    stk_seq u_seq (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .wide(wide), .wr_word(wr_word), .sp_wr_en(sp_wr_en),
        .refused(refused), .op(op), .busy(busy), .conflict_err(conflict_err)
    );

    stk_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BASE_SP(BASE_SP)) u_ptr (
        .clk(clk), .rst(rst), .op(op), .sp_wr_en(sp_wr_en),
        .sp_wr_val(sp_wr_val), .sp(sp_out), .refused(refused),
        .do_push(do_push), .do_pop(do_pop), .waddr(waddr), .raddr(raddr),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    stk_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(do_push), .waddr(waddr), .wdata(op.data),
        .raddr(raddr), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_byte    <= '0;
            rd_valid   <= 1'b0;
            rd_word    <= '0;
            word_valid <= 1'b0;
            hi_q       <= '0;
        end else begin
            rd_valid   <= do_pop;
            word_valid <= do_pop && op.tag == TAG_WIDE_LAST;
            if (do_pop) rd_byte <= rdata;
            if (do_pop && op.tag == TAG_WIDE_FIRST) hi_q <= rdata;
            if (do_pop && op.tag == TAG_WIDE_LAST)  rd_word <= {hi_q, rdata};
        end
    end

    // R4: every accepted pop yields a data strobe one cycle later
    a_r4_pop_strobe: assert property (@(posedge clk) disable iff (rst)
        do_pop |=> rd_valid);

    // R9: a pop at the base yields no data strobe
    a_r9_no_read_at_base: assert property (@(posedge clk) disable iff (rst)
        (op.valid && !op.is_push && sp_out <= BASE_SP) |=> !rd_valid);

    // R6: a word strobe always comes with a byte strobe
    a_r6_word_with_byte: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> rd_valid);
endmodule

// File: tb/byte_stack_unit_test.sv
`timescale 1ns/1ps
module byte_stack_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_req = 1'b0, pop_req = 1'b0, wide = 1'b0;
    logic [15:0] wr_word = '0;
    logic        sp_wr_en = 1'b0;
    logic [7:0]  sp_wr_val = '0;
    logic [7:0]  sp_out, rd_byte;
    logic        rd_valid, word_valid, busy, conflict_err, ovf_flag, udf_flag;
    logic [15:0] rd_word;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    byte_stack_unit uut (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .wide(wide), .wr_word(wr_word), .sp_wr_en(sp_wr_en),
        .sp_wr_val(sp_wr_val), .sp_out(sp_out), .rd_byte(rd_byte),
        .rd_valid(rd_valid), .rd_word(rd_word), .word_valid(word_valid),
        .busy(busy), .conflict_err(conflict_err), .ovf_flag(ovf_flag),
        .udf_flag(udf_flag)
    );

    task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push_byte(logic [7:0] b);
        push_req = 1'b1; wide = 1'b0; wr_word = {8'h00, b};
        @(negedge clk);
        push_req = 1'b0;
    endtask

    task automatic pop_byte();
        pop_req = 1'b1; wide = 1'b0;
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    task automatic load_sp(logic [7:0] v);
        sp_wr_en = 1'b1; sp_wr_val = v;
        @(negedge clk);
        sp_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R2", "sp after reset", 16'(sp_out), 16'h07);
        chk("R2", "flags after reset", {13'b0, ovf_flag, udf_flag, conflict_err}, 16'h0);
        chk("R2", "strobes after reset", {13'b0, rd_valid, word_valid, busy}, 16'h0);
    endtask

    task automatic t_lifo();
        do_reset();
        push_byte(8'hA1);
        chk("R3", "sp after first push", 16'(sp_out), 16'h08);
        push_byte(8'hA2);
        chk("R3", "sp after second push", 16'(sp_out), 16'h09);
        pop_byte();
        chk("R11", "first pop byte", {7'b0, rd_valid, rd_byte}, {8'h01, 8'hA2});
        chk("R4", "sp after pop", 16'(sp_out), 16'h08);
        pop_byte();
        chk("R1", "second pop byte", {7'b0, rd_valid, rd_byte}, {8'h01, 8'hA1});
        chk("R4", "sp back at base", 16'(sp_out), 16'h07);
        @(negedge clk);
        chk("R4", "strobe drops", 16'(rd_valid), 16'h0);
    endtask

    task automatic t_wide_push_order();
        do_reset();
        push_req = 1'b1; wide = 1'b1; wr_word = 16'h1234;
        @(negedge clk);
        push_req = 1'b0; wide = 1'b0;
        pop_req  = 1'b1;  // ignored while busy
        chk("R5", "busy in second slot", 16'(busy), 16'h1);
        @(negedge clk);
        pop_req = 1'b0;
        chk("R5", "sp after wide push", 16'(sp_out), 16'h09);
        chk("R5", "busy cleared", 16'(busy), 16'h0);
        pop_byte();
        chk("R5", "high byte on top", 16'(rd_byte), 16'h12);
        pop_byte();
        chk("R5", "low byte below", 16'(rd_byte), 16'h34);
    endtask

    task automatic t_wide_pop();
        do_reset();
        push_req = 1'b1; wide = 1'b1; wr_word = 16'hBEEF;
        @(negedge clk);
        push_req = 1'b0; wide = 1'b0;
        @(negedge clk);
        pop_req = 1'b1; wide = 1'b1;
        @(negedge clk);
        pop_req = 1'b0; wide = 1'b0;
        chk("R6", "first popped is high", {7'b0, rd_valid, rd_byte}, {8'h01, 8'hBE});
        chk("R6", "no word yet", 16'(word_valid), 16'h0);
        @(negedge clk);
        chk("R6", "second popped is low", 16'(rd_byte), 16'h00EF);
        chk("R6", "word strobe", 16'(word_valid), 16'h1);
        chk("R6", "assembled word", rd_word, 16'hBEEF);
        chk("R6", "sp after wide pop", 16'(sp_out), 16'h07);
    endtask

    task automatic t_conflict();
        do_reset();
        push_byte(8'h5A);
        push_req = 1'b1; pop_req = 1'b1; wr_word = 16'h00C3;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
        chk("R7", "error pulse", 16'(conflict_err), 16'h1);
        chk("R7", "sp unchanged", 16'(sp_out), 16'h08);
        chk("R7", "no read", 16'(rd_valid), 16'h0);
        @(negedge clk);
        chk("R7", "error one cycle", 16'(conflict_err), 16'h0);
        pop_byte();
        chk("R7", "stack intact", 16'(rd_byte), 16'h5A);
    endtask

    task automatic t_overflow();
        do_reset();
        load_sp(8'h7E);
        push_byte(8'h44);
        chk("R8", "top slot filled", 16'(sp_out), 16'h7F);
        push_byte(8'h99);
        chk("R8", "sp held at top", 16'(sp_out), 16'h7F);
        chk("R8", "ovf set", 16'(ovf_flag), 16'h1);
        pop_byte();
        chk("R8", "top byte not overwritten", 16'(rd_byte), 16'h44);
        chk("R8", "ovf sticky", 16'(ovf_flag), 16'h1);
    endtask

    task automatic t_underflow();
        do_reset();
        pop_byte();
        chk("R9", "no strobe at base", 16'(rd_valid), 16'h0);
        chk("R9", "sp held at base", 16'(sp_out), 16'h07);
        chk("R9", "udf set", 16'(udf_flag), 16'h1);
        push_byte(8'h11);
        chk("R9", "udf sticky", 16'(udf_flag), 16'h1);
    endtask

    task automatic t_load_priority();
        do_reset();
        load_sp(8'h1F);
        push_byte(8'h66);
        sp_wr_en = 1'b1; sp_wr_val = 8'h20; push_req = 1'b1; wr_word = 16'h0077;
        @(negedge clk);
        sp_wr_en = 1'b0; push_req = 1'b0;
        chk("R10", "load beats push", 16'(sp_out), 16'h20);
        pop_byte();
        chk("R10", "slot holds earlier byte", 16'(rd_byte), 16'h66);
        // load landing in the second slot of a wide push
        load_sp(8'h10);
        push_req = 1'b1; wide = 1'b1; wr_word = 16'hABCD;
        @(negedge clk);
        push_req = 1'b0; wide = 1'b0;
        sp_wr_en = 1'b1; sp_wr_val = 8'h30;
        @(negedge clk);
        sp_wr_en = 1'b0;
        chk("R10", "second byte cancelled", 16'(sp_out), 16'h30);
        chk("R10", "busy ended", 16'(busy), 16'h0);
        load_sp(8'h11);
        pop_byte();
        chk("R10", "low byte kept", 16'(rd_byte), 16'h00CD);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_lifo();
        t_wide_push_order();
        t_wide_pop();
        t_conflict();
        t_overflow();
        t_underflow();
        t_load_priority();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung (R11 sequence), got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule